// File: doc/BRIEF.md
# Lookahead-Carry Loadable Up/Down Counter

A synchronous binary counter, 16 bits wide by default, that steps by one per clock in either direction, takes a parallel load, holds, and flags its terminal count. It serves as a fixed-latency event or address counter that must reach a high clock rate. The carry path therefore has a fixed depth and does not grow with the bit position.

The count is split into 2-bit cells. Every cell moves on a carry that says all lower bits sit at their wrap value: all ones when counting up, all zeros when counting down. Those carries are not rippled. Narrow decodes over the low half of each nibble and full decodes over each whole nibble are formed in parallel from the count. A second level of AND gates combines them into one carry per cell. The terminal-count flag is the AND of all nibble decodes.

One synchronous clear brings the count to zero. The register enable is the OR of count enable and load enable, so a load takes effect whether counting is enabled or not.

Top module: `lookahead_updown_counter`

## Requirements
- R1: When `rst` is high at a rising clock edge, `countOut` becomes 0 on that edge.
- R2: When `loadEn` is high and `rst` low at an edge, `countOut` takes `loadValue`, whatever `countEn` and `countUp` are.
- R3: With `countEn` high, `loadEn` and `rst` low and `countUp` = 1, `countOut` increments by one per edge and wraps from 0xFFFF to 0x0000.
- R4: With `countEn` high, `loadEn` and `rst` low and `countUp` = 0, `countOut` decrements by one per edge and wraps from 0x0000 to 0xFFFF.
- R5: With `countEn`, `loadEn` and `rst` all low, `countOut` holds its value and `loadValue` has no effect.
- R6: `termCount` is combinational: it is 1 exactly when `countUp` = 1 and `countOut` is all ones, or when `countUp` = 0 and `countOut` is all zeros. It follows a change of `countUp` without waiting for a clock edge.
- R7: Carries cross every cell and nibble boundary correctly, including 0x00FF to 0x0100, 0x0FFF to 0x1000 and the reverse transitions when counting down.
- R8: `rst` takes priority over `loadEn` and `countEn` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous clear, active high |
| countEn | input | 1 | Count enable, active high |
| loadEn | input | 1 | Parallel load enable, active high, overrides counting |
| countUp | input | 1 | Direction: 1 counts up, 0 counts down |
| loadValue | input | WIDTH | Value taken on a load |
| countOut | output | WIDTH | Current count |
| termCount | output | 1 | Terminal-count flag for the current direction |

## Verification
A wrong carry term does not show until the count reaches the one pattern that needs that term, such as the low 12 bits all ones. It then shows as a count error on the very next edge. Because of this, the count is swept through every value in both directions, and the bench compares the count after every edge, so each carry term is exercised at its boundary. A fault in the nibble decodes also shows on `termCount` before the edge, since that flag reads the same decodes. Random mixes of load, clear, hold and direction cover how the controls interact.

// File: rtl/ctr_pkg.sv
package ctr_pkg;

  // Strobes from control to datapath for one clock edge.
  typedef struct packed {
    logic clear;   // synchronous clear of the count register
    logic regEn;   // register enable: count OR load
    logic load;    // take the parallel value
    logic step;    // advance by one in the selected direction
  } ctrStrobe_t;

endpackage

// File: rtl/ctr_control.sv
module ctr_control
  import ctr_pkg::*;
(
  input  logic       rst,
  input  logic       countEn,
  input  logic       loadEn,
  output ctrStrobe_t strobes
);

  always_comb begin
    strobes.clear = rst;
    strobes.regEn = countEn | loadEn;
    strobes.load  = loadEn;
    strobes.step  = countEn & ~loadEn;
  end

endmodule

// File: rtl/ctr_group_decode.sv
// First lookahead level: parallel decodes of each nibble and of the low
// half of each nibble, matched against the wrap value for the direction.
module ctr_group_decode #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0]   countVal,
  input  logic               countUp,
  output logic [WIDTH/4-1:0] halfDec,
  output logic [WIDTH/4-1:0] quadDec
);

  localparam int NQUAD = WIDTH / 4;

  for (genvar g = 0; g < NQUAD; g++) begin : gNibble
    logic [3:0] nib;
    assign nib        = countVal[4*g +: 4];
    assign halfDec[g] = countUp ? (&nib[1:0]) : ~(|nib[1:0]);
    assign quadDec[g] = countUp ? (&nib)      : ~(|nib);
  end

endmodule

// File: rtl/ctr_carry_lookahead.sv
// Second lookahead level: each 2-bit cell's carry is the AND of all full
// nibble decodes below it, plus the low-half decode of its own nibble when
// the cell is the upper pair of that nibble.
module ctr_carry_lookahead #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH/4-1:0] halfDec,
  input  logic [WIDTH/4-1:0] quadDec,
  output logic [WIDTH/2-1:0] pairCarry,
  output logic               allWrap
);

  localparam int NPAIR = WIDTH / 2;

  for (genvar k = 0; k < NPAIR; k++) begin : gCarry
    localparam int QBELOW = k / 2;
    logic quadAll;
    if (QBELOW == 0) begin : gNoQuad
      assign quadAll = 1'b1;
    end else begin : gQuad
      assign quadAll = &quadDec[QBELOW-1:0];
    end
    if ((k % 2) == 1) begin : gUpperPair
      assign pairCarry[k] = quadAll & halfDec[QBELOW];
    end else begin : gLowerPair
      assign pairCarry[k] = quadAll;
    end
  end

  assign allWrap = &quadDec;

endmodule

// File: rtl/ctr_datapath.sv
module ctr_datapath
  import ctr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  ctrStrobe_t       strobes,
  input  logic             countUp,
  input  logic [WIDTH-1:0] loadValue,
  output logic [WIDTH-1:0] countOut,
  output logic             termCount
);

  localparam int NPAIR = WIDTH / 2;
  localparam int NQUAD = WIDTH / 4;

  logic [WIDTH-1:0] countReg;
  logic [WIDTH-1:0] stepped;
  logic [NQUAD-1:0] halfDec;
  logic [NQUAD-1:0] quadDec;
  logic [NPAIR-1:0] pairCarry;

  ctr_group_decode #(.WIDTH(WIDTH)) uDecode (
    .countVal (countReg),
    .countUp  (countUp),
    .halfDec  (halfDec),
    .quadDec  (quadDec)
  );

  ctr_carry_lookahead #(.WIDTH(WIDTH)) uCarry (
    .halfDec   (halfDec),
    .quadDec   (quadDec),
    .pairCarry (pairCarry),
    .allWrap   (termCount)
  );

  // 2-bit cells: the low bit toggles on the carry; the high bit toggles when
  // the carry is present and the low bit sits at the wrap value.
  for (genvar k = 0; k < NPAIR; k++) begin : gCell
    logic lo;
    logic hi;
    assign lo = countReg[2*k];
    assign hi = countReg[2*k+1];
    assign stepped[2*k]   = lo ^ pairCarry[k];
    assign stepped[2*k+1] = hi ^ (pairCarry[k] & (lo == countUp));
  end

  always_ff @(posedge clk) begin
    if (strobes.clear) begin
      countReg <= '0;
    end else if (strobes.regEn) begin
      if (strobes.load) begin
        countReg <= loadValue;
      end else if (strobes.step) begin
        countReg <= stepped;
      end
    end
  end

  assign countOut = countReg;

endmodule

// File: rtl/lookahead_updown_counter.sv
module lookahead_updown_counter
  import ctr_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             countEn,
  input  logic             loadEn,
  input  logic             countUp,
  input  logic [WIDTH-1:0] loadValue,
  output logic [WIDTH-1:0] countOut,
  output logic             termCount
);

  ctrStrobe_t strobes;

  ctr_control uControl (
    .rst     (rst),
    .countEn (countEn),
    .loadEn  (loadEn),
    .strobes (strobes)
  );

  ctr_datapath #(.WIDTH(WIDTH)) uDatapath (
    .clk       (clk),
    .strobes   (strobes),
    .countUp   (countUp),
    .loadValue (loadValue),
    .countOut  (countOut),
    .termCount (termCount)
  );

endmodule

// File: rtl/ctr_checker.sv
module ctr_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             countEn,
  input logic             loadEn,
  input logic             countUp,
  input logic [WIDTH-1:0] loadValue,
  input logic [WIDTH-1:0] countOut,
  input logic             termCount
);

  // R1 and R8: clear wins over everything else
  a_r1_clear: assert property (@(posedge clk) rst |=> countOut == '0);

  // R2: load takes the parallel value
  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> countOut == $past(loadValue));

  // R3: up step with wrap
  a_r3_up_step: assert property (@(posedge clk) disable iff (rst)
    (countEn && !loadEn && countUp) |=> countOut == WIDTH'($past(countOut) + 1'b1));

  // R4: down step with wrap
  a_r4_down_step: assert property (@(posedge clk) disable iff (rst)
    (countEn && !loadEn && !countUp) |=> countOut == WIDTH'($past(countOut) - 1'b1));

  // R5: hold
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!countEn && !loadEn) |=> $stable(countOut));

  // R6: terminal-count flag matches the count and direction
  a_r6_term_count: assert property (@(posedge clk) disable iff (rst)
    termCount == (countUp ? (countOut == '1) : (countOut == '0)));

endmodule

bind lookahead_updown_counter ctr_checker #(.WIDTH(WIDTH)) uChecker (
  .clk       (clk),
  .rst       (rst),
  .countEn   (countEn),
  .loadEn    (loadEn),
  .countUp   (countUp),
  .loadValue (loadValue),
  .countOut  (countOut),
  .termCount (termCount)
);

// File: tb/tb_lookahead_updown_counter.sv
module tb_lookahead_updown_counter;

  localparam int W = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst = 1'b1;
  logic         countEn = 1'b0;
  logic         loadEn = 1'b0;
  logic         countUp = 1'b1;
  logic [W-1:0] loadValue = '0;
  logic [W-1:0] countOut;
  logic         termCount;

  int passCount = 0;
  int totalCount = 0;
  logic [W-1:0] refCount = '0;
  bit refValid = 1'b0;
  bit done = 1'b0;

  lookahead_updown_counter #(.WIDTH(W)) dut (
    .clk       (clk),
    .rst       (rst),
    .countEn   (countEn),
    .loadEn    (loadEn),
    .countUp   (countUp),
    .loadValue (loadValue),
    .countOut  (countOut),
    .termCount (termCount)
  );

  function automatic logic expTc(logic [W-1:0] c, logic up);
    return up ? (c == '1) : (c == '0);
  endfunction

  task automatic check(bit ok, string tag, string what, longint act, longint exp);
    totalCount++;
    if (ok) passCount++;
    else $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
  endtask

  // Called just after a falling edge; applies inputs, checks the flag before
  // the edge, then checks the count after the edge.
  task automatic doCycle(logic r, logic pe, logic ce, logic up,
                         logic [W-1:0] v, string tag);
    rst = r; loadEn = pe; countEn = ce; countUp = up; loadValue = v;
    #1;
    if (refValid)
      check(termCount === expTc(refCount, up), "R6", "termCount",
            longint'(termCount), longint'(expTc(refCount, up)));
    @(posedge clk);
    if (r) refCount = '0;
    else if (pe) refCount = v;
    else if (ce) refCount = up ? refCount + 1'b1 : refCount - 1'b1;
    refValid = 1'b1;
    @(negedge clk);
    check(countOut === refCount, tag, "countOut", longint'(countOut), longint'(refCount));
  endtask

  initial begin
    @(negedge clk);
    // R1: clear
    doCycle(1'b1, 1'b0, 1'b0, 1'b1, '0, "R1");
    // R3 / R7: full up sweep with wrap back to zero
    for (int i = 0; i < 65536; i++)
      doCycle(1'b0, 1'b0, 1'b1, 1'b1, '0, (refCount[7:0] == 8'hFF) ? "R7" : "R3");
    // R4 / R7: full down sweep with wrap through 0xFFFF
    for (int i = 0; i < 65536; i++)
      doCycle(1'b0, 1'b0, 1'b1, 1'b0, '0, (refCount[7:0] == 8'h00) ? "R7" : "R4");
    // R2: load with and without counting
    doCycle(1'b0, 1'b1, 1'b0, 1'b1, 16'h1234, "R2");
    doCycle(1'b0, 1'b1, 1'b1, 1'b0, 16'hFFFF, "R2");
    // R5: hold ignores loadValue
    for (int i = 0; i < 3; i++)
      doCycle(1'b0, 1'b0, 1'b0, i[0], 16'hAAAA, "R5");
    // R6: flag follows direction without a clock edge (count is 0xFFFF)
    countUp = 1'b1; #1;
    check(termCount === 1'b1, "R6", "termCount up at all ones", longint'(termCount), 1);
    countUp = 1'b0; #1;
    check(termCount === 1'b0, "R6", "termCount down at all ones", longint'(termCount), 0);
    @(negedge clk);
    // R8: clear beats load and count
    doCycle(1'b1, 1'b1, 1'b1, 1'b1, 16'h5555, "R8");
    // R7: targeted boundaries reached by load then step
    doCycle(1'b0, 1'b1, 1'b0, 1'b1, 16'h0FFF, "R2");
    doCycle(1'b0, 1'b0, 1'b1, 1'b1, '0, "R7");
    doCycle(1'b0, 1'b0, 1'b1, 1'b0, '0, "R7");
    // Random mix of all controls
    for (int i = 0; i < 3000; i++)
      doCycle(($urandom % 50) == 0, ($urandom % 8) == 0, $urandom % 2,
              $urandom % 2, W'($urandom), "R3");
    done = 1'b1;
    $display("%0d/%0d checks passed", passCount, totalCount);
    $finish;
  end

  initial begin
    repeat (199000) @(posedge clk);
    if (!done) begin
      totalCount++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("%0d/%0d checks passed", passCount, totalCount);
      $finish;
    end
  end

endmodule